// File: doc/BRIEF.md
# Pulse Width and Period Capture Timer

This block measures an external rectangular waveform arriving on one input pin. An internal counter runs on the system clock. Each time a measurement edge arrives, the counter's value is copied into one of two hidden buffers. One buffer holds the active-phase width and the other holds the full period. The buffer contents are then moved into two visible registers. In the same clock cycle, an interrupt latch is set. This move happens as one atomic event.

A polarity bit chooses whether a rising or a falling edge opens a measurement. A report-timing bit chooses when the visible registers refresh. With the bit set, they refresh on the edge that closes a period. With the bit clear, they refresh on the edge that closes the active phase, and the period register then shows the period measured before. The pin is synchronized by two flops before edge detection. The counter restarts at one on each period and saturates at its all-ones value rather than wrapping.

Top module: `pwcap_timer`

## Requirements
- R1: Capture runs only when `cap_en` is 1 and `cap_mode` equals binary 10. In any other setting, the visible registers do not change, the interrupt latch is not set, and the counter is held at 1 in the idle state.
- R2: With `cap_pol_hi` = 1, a rising pin edge opens a measurement and a falling edge closes the active phase. With `cap_pol_hi` = 0, the roles of the two edges are swapped.
- R3: From the first opening edge onward, the counter starts at 1 and adds 1 per clock. The width is the number of clocks from an opening edge to the following closing edge.
- R4: At each opening edge after the first, the period buffer takes the count, which is the number of clocks since the previous opening edge. The counter then restarts at 1.
- R5: With `rpt_on_lead` = 1, both visible registers and the interrupt refresh together on the opening edge that ends a period. This happens on the third rising clock edge after the pin changes.
- R6: With `rpt_on_lead` = 0, the refresh happens on the closing edge instead. The width register takes the new width. The period register takes the period buffer, which holds the previous period. The buffers are cleared while the block is not capturing, so the first report shows a period of 0.
- R7: A refresh sets `irq_flag` only when `irq_en` is 1. With `irq_en` = 0, the registers still refresh but the flag is left alone.
- R8: A 1 on `irq_clr` clears `irq_flag` on the next clock. If a refresh with `irq_en` = 1 falls in the same cycle, the flag stays set.
- R9: The counter stops at its all-ones value (2^CNT_W - 1) instead of wrapping to 0.
- R10: Leaving capture mode returns the block to idle. It leaves `width_val` and `period_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Block enable |
| cap_mode | input | 2 | Mode field; binary 10 selects capture |
| cap_pol_hi | input | 1 | 1: rising edge opens a measurement; 0: falling edge opens |
| rpt_on_lead | input | 1 | 1: refresh on opening edge; 0: refresh on closing edge |
| irq_en | input | 1 | Allows a refresh to set the interrupt latch |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt latch |
| sig_in | input | 1 | Asynchronous waveform input |
| width_val | output | CNT_W | Visible width register |
| period_val | output | CNT_W | Visible period register |
| irq_flag | output | 1 | Interrupt latch |

## Verification
Every internal fault here shows up as a wrong number in `width_val` or `period_val`, or as a missing or extra `irq_flag`. A fault in the counter, a buffer, or the idle/run state appears at the first refresh after the fault. This is at most one waveform period later, and three clocks after the refresh edge enters the synchronizer. A fault in the choice of opening and closing edge swaps width with the inactive phase, so widths and periods are chosen to be unequal and asymmetric. Saturation is reached only through a narrow counter instance, where it shows as a width pinned at the all-ones value.

// File: rtl/pwcap_pkg.sv
// Package: shared types and constants for the capture timer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwcap_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} cap_state_t;
    localparam logic [1:0] MODE_CAPTURE = 2'b10;
endpackage

// File: rtl/pwcap_sync.sv
// Module: brings the asynchronous pin into the clock domain through
// SYNC_STAGES flops, then flags a rising or falling change between two
// consecutive synchronized samples.
// Assumes: SYNC_STAGES >= 2; the edge flags are valid one cycle after the
// last synchronizer stage sees the new level.
module pwcap_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // Shift the pin through the synchronizer chain and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], pin};
            prev  <= chain[LAST];
        end
    end

    // Compare the current synchronized sample with the previous one.
    always_comb begin
        rise = chain[LAST] & ~prev;
        fall = ~chain[LAST] & prev;
    end
endmodule

// File: rtl/pwcap_core.sv
// Module: counter, idle/run state and hidden width/period buffers. It also
// decides when a refresh event fires and which values that event carries.
// Assumes: rise and fall are single-cycle and never coincide.
module pwcap_core
    import pwcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             pol_hi,
    input  logic             rpt_lead,
    input  logic             rise,
    input  logic             fall,
    output logic             upd,
    output logic [CNT_W-1:0] upd_width,
    output logic [CNT_W-1:0] upd_period,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cap_state_t       state;
    logic [CNT_W-1:0] wbuf;
    logic [CNT_W-1:0] pbuf;
    logic             lead;
    logic             trail;

    // Map the physical edges onto opening and closing edges by polarity.
    always_comb begin
        lead  = pol_hi ? rise : fall;
        trail = pol_hi ? fall : rise;
    end

    // Counter, run state and buffer capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state <= ST_IDLE;
            count <= CNT_ONE;
            wbuf  <= '0;
            pbuf  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (lead) state <= ST_RUN;
                default: begin
                    if (lead) begin
                        pbuf  <= count;
                        count <= CNT_ONE;
                    end else if (count != CNT_MAX) begin
                        count <= count + CNT_ONE;
                    end
                    if (trail) wbuf <= count;
                end
            endcase
        end
    end

    // Refresh event and the values that pass through it in the same cycle.
    always_comb begin
        upd        = active && (state == ST_RUN) && (rpt_lead ? lead : trail);
        upd_width  = trail ? count : wbuf;
        upd_period = lead  ? count : pbuf;
    end
endmodule

// File: rtl/pwcap_report.sv
// Module: visible width/period registers and the interrupt latch.
// Assumes: upd is a single-cycle strobe from the core.
module pwcap_report #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CNT_W-1:0] upd_width,
    input  logic [CNT_W-1:0] upd_period,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] width_val,
    output logic [CNT_W-1:0] period_val,
    output logic             irq_flag
);
    // Load both visible registers together on a refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_val  <= '0;
            period_val <= '0;
        end else if (upd) begin
            width_val  <= upd_width;
            period_val <= upd_period;
        end
    end

    // Interrupt latch: setting wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_flag <= 1'b0;
        else        irq_flag <= (upd && irq_en) || (irq_flag && !irq_clr);
    end
endmodule

// File: rtl/pwcap_timer.sv
// Module: top of the pulse width and period capture timer. It wires the
// synchronizer, the counting core and the reporting registers together.
// Assumes: sig_in may be fully asynchronous; configuration inputs are static
// or change only between measurements.
module pwcap_timer
    import pwcap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [1:0]       cap_mode,
    input  logic             cap_pol_hi,
    input  logic             rpt_on_lead,
    input  logic             irq_en,
    input  logic             irq_clr,
    input  logic             sig_in,
    output logic [CNT_W-1:0] width_val,
    output logic [CNT_W-1:0] period_val,
    output logic             irq_flag
);
    logic             active;
    logic             rise_evt;
    logic             fall_evt;
    logic             upd_evt;
    logic [CNT_W-1:0] nxt_width;
    logic [CNT_W-1:0] nxt_period;
    logic [CNT_W-1:0] cnt_now;

    // Capture is active only in the enabled capture mode.
    always_comb active = cap_en && (cap_mode == MODE_CAPTURE);

    pwcap_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sig_in),
        .rise (rise_evt),
        .fall (fall_evt)
    );

    pwcap_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .pol_hi    (cap_pol_hi),
        .rpt_lead  (rpt_on_lead),
        .rise      (rise_evt),
        .fall      (fall_evt),
        .upd       (upd_evt),
        .upd_width (nxt_width),
        .upd_period(nxt_period),
        .count     (cnt_now)
    );

    pwcap_report #(.CNT_W(CNT_W)) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd_evt),
        .upd_width (nxt_width),
        .upd_period(nxt_period),
        .irq_en    (irq_en),
        .irq_clr   (irq_clr),
        .width_val (width_val),
        .period_val(period_val),
        .irq_flag  (irq_flag)
    );
endmodule

// File: rtl/pwcap_checker.sv
// Module: assertion checker for pwcap_timer, attached by bind below.
// Assumes: it observes the top's ports and its internal event and counter nets.
module pwcap_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active,
    input logic             upd,
    input logic             irq_en,
    input logic             irq_clr,
    input logic             irq_flag,
    input logic [CNT_W-1:0] width_val,
    input logic [CNT_W-1:0] period_val,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    AST_OFF_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !upd);                                                      // R1
    AST_OFF_COUNT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt == CNT_W'(1));                                          // R1
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(width_val) && $stable(period_val));                    // R10
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd && irq_en |=> irq_flag);                                            // R7
    AST_IRQ_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_flag && !(upd && irq_en) |=> !irq_flag);                           // R7
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !(upd && irq_en) |=> !irq_flag);                             // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        active && cnt == ALL_ONES |=> cnt == ALL_ONES || cnt == CNT_W'(1));     // R9
endmodule

bind pwcap_timer pwcap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .upd       (upd_evt),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .irq_flag  (irq_flag),
    .width_val (width_val),
    .period_val(period_val),
    .cnt       (cnt_now)
);

// File: tb/pwcap_timer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module pwcap_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [1:0]  cap_mode = 2'b00;
    logic        cap_pol_hi = 1'b1;
    logic        rpt_on_lead = 1'b1;
    logic        irq_en = 1'b1;
    logic        irq_clr = 1'b0;
    logic        sig_in = 1'b0;
    logic [31:0] width_val;
    logic [31:0] period_val;
    logic        irq_flag;

    logic        s_en = 1'b0;
    logic        s_sig = 1'b0;
    logic [3:0]  s_width;
    logic [3:0]  s_period;
    logic        s_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwcap_timer u_pwcap_timer (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_mode(cap_mode),
        .cap_pol_hi(cap_pol_hi), .rpt_on_lead(rpt_on_lead), .irq_en(irq_en),
        .irq_clr(irq_clr), .sig_in(sig_in), .width_val(width_val),
        .period_val(period_val), .irq_flag(irq_flag)
    );

    pwcap_timer #(.CNT_W(4)) u_pwcap_timer_small (
        .clk(clk), .rst_n(rst_n), .cap_en(s_en), .cap_mode(2'b10),
        .cap_pol_hi(1'b1), .rpt_on_lead(1'b0), .irq_en(1'b1),
        .irq_clr(1'b0), .sig_in(s_sig), .width_val(s_width),
        .period_val(s_period), .irq_flag(s_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 reset width", width_val, 0);
        chk("R1 reset period", period_val, 0);
        chk("R1 reset irq", {31'd0, irq_flag}, 0);
    endtask

    // Rising opens, refresh on opening edge: width 5, period 12.
    task automatic t_pol_hi_lead();
        cap_pol_hi = 1'b1; rpt_on_lead = 1'b1; sig_in = 1'b0;
        cap_mode = 2'b10; cap_en = 1'b1;
        wait_n(4);
        sig_in = 1'b1;
        wait_n(5);
        sig_in = 1'b0;
        wait_n(4);
        chk("R5 no refresh on closing edge", width_val, 0);
        wait_n(3);
        sig_in = 1'b1;
        wait_n(4);
        chk("R3 width", width_val, 5);
        chk("R4 period", period_val, 12);
        chk("R5 irq on refresh", {31'd0, irq_flag}, 1);
    endtask

    task automatic t_clear();
        irq_clr = 1'b1;
        wait_n(1);
        irq_clr = 1'b0;
        wait_n(1);
        chk("R8 clear", {31'd0, irq_flag}, 0);
    endtask

    // Falling opens, refresh on closing edge with previous period.
    task automatic t_pol_lo_trail();
        cap_en = 1'b0;
        wait_n(3);
        chk("R10 width kept", width_val, 5);
        chk("R10 period kept", period_val, 12);
        sig_in = 1'b1; cap_pol_hi = 1'b0; rpt_on_lead = 1'b0;
        wait_n(4);
        cap_en = 1'b1;
        wait_n(3);
        sig_in = 1'b0;
        wait_n(3);
        sig_in = 1'b1;
        wait_n(4);
        chk("R6 first width", width_val, 3);
        chk("R6 first period zero", period_val, 0);
        chk("R2 falling-open irq", {31'd0, irq_flag}, 1);
        wait_n(4);
        sig_in = 1'b0;
        wait_n(4);
        chk("R6 no refresh on opening edge", width_val, 3);
        chk("R6 period unchanged", period_val, 0);
        wait_n(2);
        sig_in = 1'b1;
        wait_n(4);
        chk("R2 width falling-open", width_val, 6);
        chk("R6 previous period", period_val, 11);
    endtask

    task automatic t_wrong_mode();
        cap_en = 1'b0;
        irq_clr = 1'b1;
        wait_n(1);
        irq_clr = 1'b0;
        cap_mode = 2'b01; cap_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sig_in = 1'b0; wait_n(4);
            sig_in = 1'b1; wait_n(5);
        end
        chk("R1 wrong mode width", width_val, 6);
        chk("R1 wrong mode period", period_val, 11);
        chk("R1 wrong mode irq", {31'd0, irq_flag}, 0);
    endtask

    task automatic t_irq_masked();
        cap_en = 1'b0; sig_in = 1'b0;
        cap_mode = 2'b10; cap_pol_hi = 1'b1; rpt_on_lead = 1'b1; irq_en = 1'b0;
        wait_n(4);
        cap_en = 1'b1;
        wait_n(2);
        sig_in = 1'b1; wait_n(2);
        sig_in = 1'b0; wait_n(3);
        sig_in = 1'b1; wait_n(4);
        chk("R7 masked width", width_val, 2);
        chk("R7 masked period", period_val, 5);
        chk("R7 masked irq", {31'd0, irq_flag}, 0);
    endtask

    // Clear pulse seen in the same cycle as a refresh.
    task automatic t_collision();
        irq_en = 1'b1;
        sig_in = 1'b0; wait_n(3);
        sig_in = 1'b1;
        wait_n(2);
        irq_clr = 1'b1;
        wait_n(1);
        irq_clr = 1'b0;
        wait_n(1);
        chk("R8 set wins over clear", {31'd0, irq_flag}, 1);
        irq_clr = 1'b1;
        wait_n(1);
        irq_clr = 1'b0;
        wait_n(1);
        chk("R8 clear after collision", {31'd0, irq_flag}, 0);
    endtask

    task automatic t_saturate();
        s_en = 1'b1;
        wait_n(3);
        s_sig = 1'b1; wait_n(3);
        s_sig = 1'b0; wait_n(4);
        s_sig = 1'b1; wait_n(20);
        s_sig = 1'b0; wait_n(4);
        chk("R9 saturated width", {28'd0, s_width}, 15);
        chk("R9 period before saturation", {28'd0, s_period}, 7);
    endtask

    initial begin
        t_reset();
        t_pol_hi_lead();
        t_clear();
        t_pol_lo_trail();
        t_wrong_mode();
        t_irq_masked();
        t_collision();
        t_saturate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule